// File: doc/BRIEF.md
# Button-Driven Step Counter

This block keeps a small count that three push buttons control. One button lowers the count by one, one raises it by four, and one clears it. All three button lines are asynchronous levels. Each is brought into the single system clock domain by a two-flop synchroniser. A short history register then records its recent samples, and a press counts only when that history shows a clean rising pattern. Each press yields exactly one update of the count.

The buttons never clock anything. The count register has a single clocked writer, and a recognised press acts on it as a one-cycle enable. When several presses are recognised in the same cycle, the clear wins over the raise, and the raise wins over the lower. Arithmetic wraps around the width of the count.

Top module: `btn_step_counter`

## Requirements
- R1: While `rst_n` is low, all internal state and `count` are held at zero, and `count` is still zero on the first cycle after release.
- R2: Each button passes through two synchronising flops and then into a 3-bit history with the newest sample in bit 0, so a press affects `count` no earlier than the fourth rising edge after the first edge that samples the button high.
- R3: A press is recognised when a button's history equals 3'b011 (the two newest samples high, the oldest low). `count` changes right after the fourth rising edge that follows the first edge sampling the button high, and it holds its value in every cycle without a recognised press.
- R4: A button held high for any number of cycles yields exactly one update.
- R5: A button that is high at only one sampling edge (history 010) causes no update.
- R6: A recognised press of `btn_down` subtracts 1 modulo 64, so 0 becomes 63.
- R7: A recognised press of `btn_up` adds 4 modulo 64, so 63 becomes 3.
- R8: A recognised press of `btn_reset` sets `count` to 0.
- R9: When presses are recognised in the same cycle, `btn_reset` overrides `btn_up`, and `btn_up` overrides `btn_down`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_down | input | 1 | Asynchronous button level, lowers count by one |
| btn_up | input | 1 | Asynchronous button level, raises count by four |
| btn_reset | input | 1 | Asynchronous button level, clears count |
| count | output | 6 | Current count value |

## Verification
The bench builds the block with its defaults: a 6-bit count, an up step of 4 and a down step of 1. With these values, both wrap points (0 minus 1, and 63 plus 4) can be reached in a few dozen presses. A behavioural model is compared against the count on every clock. Directed checks cover the exact latency edge, single-cycle glitches, long holds and every priority combination.

// File: rtl/btn_step_counter.sv
module btn_step_counter #(
  parameter int CNT_W     = 6,
  parameter int UP_STEP   = 4,
  parameter int DOWN_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_down,
  input  logic             btn_up,
  input  logic             btn_reset,
  output logic [CNT_W-1:0] count
);
  localparam int NB = 3;
  localparam int HW = 3;
  localparam logic [HW-1:0]    PRESS_PAT = 3'b011;
  localparam logic [CNT_W-1:0] UP_INC    = CNT_W'(UP_STEP);
  localparam logic [CNT_W-1:0] DN_DEC    = CNT_W'(DOWN_STEP);

  // index 0 = down, 1 = up, 2 = clear
  logic [NB-1:0] btn_in, sync_a, sync_b, hit;
  assign btn_in = {btn_reset, btn_up, btn_down};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= btn_in;
      sync_b <= sync_a;
    end

  for (genvar g = 0; g < NB; g++) begin : g_btn
    logic [HW-1:0] hist;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) hist <= '0;
      else        hist <= {hist[HW-2:0], sync_b[g]};
    assign hit[g] = (hist == PRESS_PAT);

    // R4
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> !hit[g]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      count <= '0;
    else if (hit[2]) count <= '0;
    else if (hit[1]) count <= count + UP_INC;
    else if (hit[0]) count <= count - DN_DEC;

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[2] |=> count == '0);
  // R7
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && !hit[2]) |=> count == $past(count) + UP_INC);
  // R6
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 3'b001) |=> count == $past(count) - DN_DEC);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> $stable(count));
endmodule

// File: tb/tb_btn_step_counter.sv
`timescale 1ns/1ps
module tb_btn_step_counter;
  logic clk = 0, rst_n = 0, b_dn = 0, b_up = 0, b_rs = 0;
  logic [5:0] count;
  int checks = 0, errors = 0;
  int mcount = 0;
  int hq[3][$];
  bit model_on = 0;

  btn_step_counter dut (.clk(clk), .rst_n(rst_n), .btn_down(b_dn),
    .btn_up(b_up), .btn_reset(b_rs), .count(count));

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural model: sample history per button, newest at index 0
  always @(posedge clk) begin
    if (!rst_n) begin
      mcount = 0;
      for (int b = 0; b < 3; b++) begin
        hq[b].delete();
        for (int i = 0; i < 6; i++) hq[b].push_back(0);
      end
    end else begin
      bit p[3];
      hq[0].push_front(int'(b_dn)); hq[1].push_front(int'(b_up)); hq[2].push_front(int'(b_rs));
      for (int b = 0; b < 3; b++) begin
        void'(hq[b].pop_back());
        p[b] = (hq[b][3] == 1) && (hq[b][4] == 1) && (hq[b][5] == 0);
      end
      if (p[2]) mcount = 0;
      else if (p[1]) mcount = (mcount + 4) % 64;
      else if (p[0]) mcount = (mcount + 63) % 64;
    end
  end

  always @(negedge clk)
    if (model_on) chk("R6/R7/R8/R9 model", int'(count), mcount);

  task automatic press(bit d, bit u, bit r, int n);
    @(negedge clk); b_dn = d; b_up = u; b_rs = r;
    repeat (n) @(negedge clk);
    b_dn = 0; b_up = 0; b_rs = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'(count), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'(count), 0);
    model_on = 1;
    repeat (3) @(negedge clk);

    // R2 R3 latency: first high sample at edge j, update after edge j+4
    b_up = 1;
    @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 no early update", int'(count), 0);
    @(negedge clk);
    chk("R3 update at fourth edge", int'(count), 4);
    repeat (3) @(negedge clk);
    b_up = 0;
    repeat (8) @(negedge clk);
    chk("R7 up step", int'(count), 4);

    press(1, 0, 0, 5);
    chk("R6 down step", int'(count), 3);

    press(0, 1, 0, 1);
    chk("R5 single-cycle glitch ignored", int'(count), 3);
    press(1, 0, 0, 1);
    chk("R5 single-cycle glitch ignored down", int'(count), 3);

    press(0, 1, 0, 30);
    chk("R4 long hold counts once", int'(count), 7);

    for (int i = 0; i < 8; i++) press(1, 0, 0, 3);
    chk("R6 underflow wrap", int'(count), 63);

    press(0, 1, 0, 3);
    chk("R7 overflow wrap", int'(count), 3);

    press(1, 1, 0, 3);
    chk("R9 up over down", int'(count), 7);

    press(1, 1, 1, 3);
    chk("R9 reset over all", int'(count), 0);

    press(0, 1, 0, 3);
    press(0, 0, 1, 4);
    chk("R8 reset button clears", int'(count), 0);

    press(1, 0, 1, 3);
    chk("R9 reset over down", int'(count), 0);

    model_on = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset mid-run", int'(count), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule